// File: doc/BRIEF.md
# Receive Polarity Detection and Correction

This block decides whether the two wires of the receive twisted pair have been swapped. The receive front end feeds it classified events. Link pulses arrive as either expected-polarity or opposite-polarity. Frame endings arrive as either a normal start-of-idle or a reversed one. Every event is classified against the polarity currently applied, and the block answers with a single invert flag that the receive datapath applies to the sliced signal.

Two saturating evidence counters run side by side, one for link pulses and one for frame endings, and each has its own threshold. When either counter reaches its threshold, the invert flag toggles and both counters restart. Any correctly polarised event wipes both counters. While link testing is switched off, link pulses of either kind are disregarded. A millisecond-tick silence timer returns the flag to non-inverted once the link has sat in the fail state with no receive activity for a parameterised period. Correction has no disable.

Top module: `rx_polarity_corrector`

## Requirements
- R1: After reset (asynchronous, active low), invert_o is 0 and both evidence counters are empty. A run of 7 opposite link pulses that follows a reset therefore leaves invert_o at 0.
- R2: With link_test_en_i high, a run of LP_THRESH (default 8) opposite link pulses (lp_rev_i) with no expected pulse among them toggles invert_o. The new value is visible after the clock edge that samples the last pulse.
- R3: A run of EOF_THRESH (default 4) reversed frame endings (eof_rev_i) toggles invert_o in the same way.
- R4: An expected-polarity link pulse (lp_ok_i, with link_test_en_i high) clears both the link-pulse counter and the frame counter.
- R5: A normal frame ending (eof_ok_i) clears both counters.
- R6: While link_test_en_i is 0, lp_rev_i and lp_ok_i neither add to nor clear any counter.
- R7: The two counters are independent, and each toggle is relative to the current value of invert_o. A toggle empties both counters, so a second full run toggles invert_o back.
- R8: With link_fail_i high, SILENCE_MS (default 112) ms ticks without activity force invert_o to 0.
- R9: Activity restarts the silence count. Activity is rx_active_i or any link-pulse or frame-ending input. A cycle with link_fail_i low also restarts it.
- R10: If a correctly polarised event and a reversed event of the same kind arrive in the same cycle, the correct one wins: the counters clear and nothing is counted.
- R11: ms_tick_i has no effect while link_fail_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_test_en_i | input | 1 | Link testing enabled; gates link-pulse evidence |
| lp_ok_i | input | 1 | One-cycle strobe: link pulse of expected polarity |
| lp_rev_i | input | 1 | One-cycle strobe: link pulse of opposite polarity |
| eof_ok_i | input | 1 | One-cycle strobe: frame ended with normal start-of-idle |
| eof_rev_i | input | 1 | One-cycle strobe: frame ended with reversed start-of-idle |
| link_fail_i | input | 1 | Link integrity is in the fail state |
| rx_active_i | input | 1 | Valid receive data present |
| ms_tick_i | input | 1 | One-cycle strobe every millisecond |
| invert_o | output | 1 | Receive polarity invert flag applied by the datapath |

## Verification
Every result of this block is registered one level deep. A toggle, a counter clear or a silence expiry is visible on invert_o right after the clock edge that samples the deciding strobe. The bench drives each strobe for exactly one cycle on a falling edge. It samples invert_o on the falling edge after the last strobe of a vector, which is half a cycle after the result becomes due. Counter contents that are not visible at the port are brought out through invert_o. The bench applies a run that lands exactly on, or one short of, a threshold and checks whether the flag moves.

// File: rtl/rx_pol_pkg.sv
package rx_pol_pkg;
  typedef enum int unsigned {
    SRC_LINK  = 0,
    SRC_FRAME = 1
  } ev_src_e;
  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/rx_pol_evidence_ctr.sv
module rx_pol_evidence_ctr #(
  parameter int unsigned THRESH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic good_i,
  input  logic bump_i,
  input  logic restart_i,
  output logic hit_o
);
  localparam int unsigned CW = (THRESH < 2) ? 1 : $clog2(THRESH);
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

  logic [CW-1:0] cnt_q;

  // good evidence blocks the hit in the same cycle
  assign hit_o = bump_i && !good_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (good_i || restart_i) cnt_q <= '0;
    else if (bump_i && !hit_o)    cnt_q <= cnt_q + 1'b1;
  end

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r4_good_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_i |=> cnt_q == '0);
  a_r10_good_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (good_i && bump_i) |-> !hit_o);
endmodule

// File: rtl/rx_pol_silence_timer.sv
module rx_pol_silence_timer #(
  parameter int unsigned SILENCE_MS = 112
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fail_i,
  input  logic activity_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned TW = $clog2(SILENCE_MS + 1);
  localparam logic [TW-1:0] LAST = TW'(SILENCE_MS - 1);

  logic [TW-1:0] cnt_q;
  logic          quiet;

  assign quiet    = fail_i && !activity_i;
  assign expire_o = quiet && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!quiet || expire_o) cnt_q <= '0;
    else if (tick_i)             cnt_q <= cnt_q + 1'b1;
  end

  a_r9_activity_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    activity_i |=> cnt_q == '0);
  a_r11_idle_when_linked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fail_i |=> cnt_q == '0);
endmodule

// File: rtl/rx_polarity_corrector.sv
module rx_polarity_corrector
  import rx_pol_pkg::*;
#(
  parameter int unsigned LP_THRESH  = 8,
  parameter int unsigned EOF_THRESH = 4,
  parameter int unsigned SILENCE_MS = 112
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_test_en_i,
  input  logic lp_ok_i,
  input  logic lp_rev_i,
  input  logic eof_ok_i,
  input  logic eof_rev_i,
  input  logic link_fail_i,
  input  logic rx_active_i,
  input  logic ms_tick_i,
  output logic invert_o
);
  logic               lp_ok_g, lp_rev_g, any_good, flip, expire, activity;
  logic [NUM_SRC-1:0] bump, hit;
  logic               invert_q;

  assign lp_ok_g  = lp_ok_i && link_test_en_i;
  assign lp_rev_g = lp_rev_i && link_test_en_i;
  assign any_good = lp_ok_g || eof_ok_i;

  assign bump[SRC_LINK]  = lp_rev_g;
  assign bump[SRC_FRAME] = eof_rev_i;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int unsigned TH = (s == SRC_LINK) ? LP_THRESH : EOF_THRESH;
    rx_pol_evidence_ctr #(.THRESH(TH)) u_ctr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .good_i    (any_good),
      .bump_i    (bump[s]),
      .restart_i (flip || expire),
      .hit_o     (hit[s])
    );
  end

  assign flip     = |hit;
  assign activity = rx_active_i || lp_ok_i || lp_rev_i || eof_ok_i || eof_rev_i;

  rx_pol_silence_timer #(.SILENCE_MS(SILENCE_MS)) u_silence (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fail_i     (link_fail_i),
    .activity_i (activity),
    .tick_i     (ms_tick_i),
    .expire_o   (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     invert_q <= 1'b0;
    else if (expire) invert_q <= 1'b0;
    else if (flip)   invert_q <= ~invert_q;
  end

  assign invert_o = invert_q;

  a_r8_silence_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> !invert_q);
  a_r7_relative_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip && !expire) |=> invert_q != $past(invert_q));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flip || expire) |=> $stable(invert_q));
  a_r6_pulses_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_test_en_i && !eof_rev_i) |-> !flip);
endmodule

// File: tb/tb_rx_polarity_corrector.sv
module tb_rx_polarity_corrector;
  localparam int unsigned SIL = 112;

  typedef enum logic [2:0] {
    OP_LP_REV, OP_LP_OK, OP_EOF_REV, OP_EOF_OK, OP_TICK, OP_ACT, OP_LP_BOTH
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [7:0] n;
    logic       en;
    logic       fail;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VEC [NV] = '{
    '{OP_LP_REV,  8'd7,   1'b1, 1'b0, 1'b0, 4'd2},   // R2 one short
    '{OP_LP_REV,  8'd1,   1'b1, 1'b0, 1'b1, 4'd2},   // R2 eighth
    '{OP_EOF_REV, 8'd3,   1'b1, 1'b0, 1'b1, 4'd3},   // R3 one short
    '{OP_EOF_REV, 8'd1,   1'b1, 1'b0, 1'b0, 4'd7},   // R7 toggles back
    '{OP_LP_REV,  8'd7,   1'b1, 1'b0, 1'b0, 4'd4},
    '{OP_LP_OK,   8'd1,   1'b1, 1'b0, 1'b0, 4'd4},   // R4
    '{OP_LP_REV,  8'd7,   1'b1, 1'b0, 1'b0, 4'd4},
    '{OP_LP_REV,  8'd1,   1'b1, 1'b0, 1'b1, 4'd4},
    '{OP_EOF_REV, 8'd3,   1'b1, 1'b0, 1'b1, 4'd4},
    '{OP_LP_OK,   8'd1,   1'b1, 1'b0, 1'b1, 4'd4},   // R4 clears frame ctr
    '{OP_EOF_REV, 8'd3,   1'b1, 1'b0, 1'b1, 4'd4},
    '{OP_EOF_REV, 8'd1,   1'b1, 1'b0, 1'b0, 4'd3},
    '{OP_LP_REV,  8'd6,   1'b1, 1'b0, 1'b0, 4'd5},
    '{OP_EOF_OK,  8'd1,   1'b1, 1'b0, 1'b0, 4'd5},   // R5
    '{OP_LP_REV,  8'd2,   1'b1, 1'b0, 1'b0, 4'd5},
    '{OP_LP_REV,  8'd6,   1'b1, 1'b0, 1'b1, 4'd5},
    '{OP_LP_REV,  8'd20,  1'b0, 1'b0, 1'b1, 4'd6},   // R6 ignored
    '{OP_EOF_REV, 8'd3,   1'b0, 1'b0, 1'b1, 4'd6},
    '{OP_LP_OK,   8'd1,   1'b0, 1'b0, 1'b1, 4'd6},   // R6 no clear
    '{OP_EOF_REV, 8'd1,   1'b0, 1'b0, 1'b0, 4'd6},
    '{OP_LP_REV,  8'd7,   1'b1, 1'b0, 1'b0, 4'd7},
    '{OP_EOF_REV, 8'd3,   1'b1, 1'b0, 1'b0, 4'd7},   // R7 independent
    '{OP_EOF_REV, 8'd1,   1'b1, 1'b0, 1'b1, 4'd7},
    '{OP_LP_REV,  8'd1,   1'b1, 1'b0, 1'b1, 4'd7},   // R7 toggle emptied lp ctr
    '{OP_LP_REV,  8'd7,   1'b1, 1'b0, 1'b0, 4'd7},
    '{OP_LP_REV,  8'd8,   1'b1, 1'b0, 1'b1, 4'd2},
    '{OP_TICK,    8'd200, 1'b1, 1'b0, 1'b1, 4'd11},  // R11
    '{OP_TICK,    8'd111, 1'b1, 1'b1, 1'b1, 4'd9},
    '{OP_ACT,     8'd1,   1'b1, 1'b1, 1'b1, 4'd9},   // R9
    '{OP_TICK,    8'd111, 1'b1, 1'b1, 1'b1, 4'd9},
    '{OP_TICK,    8'd1,   1'b1, 1'b1, 1'b0, 4'd8},   // R8
    '{OP_LP_REV,  8'd8,   1'b1, 1'b1, 1'b1, 4'd2},
    '{OP_TICK,    8'd111, 1'b1, 1'b1, 1'b1, 4'd9},
    '{OP_TICK,    8'd1,   1'b1, 1'b0, 1'b1, 4'd9},   // R9 link up restarts
    '{OP_TICK,    8'd111, 1'b1, 1'b1, 1'b1, 4'd9},
    '{OP_TICK,    8'd1,   1'b1, 1'b1, 1'b0, 4'd8},
    '{OP_LP_REV,  8'd7,   1'b1, 1'b0, 1'b0, 4'd10},
    '{OP_LP_BOTH, 8'd1,   1'b1, 1'b0, 1'b0, 4'd10}   // R10
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic link_test_en_i = 1'b1, lp_ok_i = 1'b0, lp_rev_i = 1'b0;
  logic eof_ok_i = 1'b0, eof_rev_i = 1'b0, link_fail_i = 1'b0;
  logic rx_active_i = 1'b0, ms_tick_i = 1'b0;
  logic invert_o;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #5 clk_i = ~clk_i;

  rx_polarity_corrector dut (
    .clk_i, .rst_ni, .link_test_en_i, .lp_ok_i, .lp_rev_i, .eof_ok_i,
    .eof_rev_i, .link_fail_i, .rx_active_i, .ms_tick_i, .invert_o
  );

  task automatic check(input logic exp, input int req);
    checks++;
    if (invert_o !== exp) begin
      fails++;
      $display("FAIL R%0d: invert_o actual %b expected %b", req, invert_o, exp);
    end
  endtask

  task automatic apply(input op_e op, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      lp_rev_i    = (op == OP_LP_REV) || (op == OP_LP_BOTH);
      lp_ok_i     = (op == OP_LP_OK)  || (op == OP_LP_BOTH);
      eof_rev_i   = (op == OP_EOF_REV);
      eof_ok_i    = (op == OP_EOF_OK);
      ms_tick_i   = (op == OP_TICK);
      rx_active_i = (op == OP_ACT);
      @(negedge clk_i);
      {lp_rev_i, lp_ok_i, eof_rev_i, eof_ok_i, ms_tick_i, rx_active_i} = '0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(1'b0, 1);                      // R1 reset value
    rst_ni = 1'b1;
    for (int v = 0; v < NV; v++) begin
      link_test_en_i = VEC[v].en;
      link_fail_i    = VEC[v].fail;
      apply(VEC[v].op, int'(VEC[v].n));
      check(VEC[v].exp, int'(VEC[v].req));
    end
    apply(OP_LP_REV, 7);                 // R10: 7 after the clear, no flip
    check(1'b0, 10);
    apply(OP_LP_REV, 1);
    check(1'b1, 10);
    // R1: reset mid-run empties counters and clears flag
    apply(OP_LP_REV, 5);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    check(1'b0, 1);
    rst_ni = 1'b1;
    apply(OP_LP_REV, 7);
    check(1'b0, 1);
    apply(OP_EOF_REV, 3);
    check(1'b0, 1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule